// File: doc/BRIEF.md
# In-Place Execution Window Partition

This block is a small out-of-order execution window in which every instruction is executed in the slot it was written into. The slots form a chain. The first slot receives the architectural register values. Each slot then hands a complete register bundle to the next slot, with its own result substituted for the register it writes. Because a slot always reads the bundle produced by the slots older than it, slot position alone resolves dependences. There is no rename table, no wakeup or select network and no multiported register file.

Register values ride the chain combinationally. Each register also carries a completion bit, and the bit for a slot's destination is registered. A slot therefore executes as soon as the completion bits of its sources are set, and readiness alone decides when work happens. Instructions are filled one per cycle in program order until the partition is full. Once every slot has completed, the final bundle is latched into the architectural registers in a single step and the partition empties for the next group.

A branch-compare slot that finds its prediction wrong raises a mispredict signal. Every younger slot, including one filled later, then becomes a pass-through no-op.

Top module: `ipw_window`

## Requirements
- R1: After a synchronous reset, all four architectural registers read 0 and `full`, `retire` and `mispredict` are low.
- R2: When `fill_valid` is high and `full` is low, the instruction is accepted at the clock edge into the next free slot in program order. `full` goes high after four instructions have been accepted.
- R3: While `full` is high, `fill_valid` is ignored until retirement. After retirement the next accepted instruction goes to the first slot.
- R4: Each slot reads its source values from the nearest older slot that writes that register, or from the architectural registers if no older slot does. The retired register values equal those of executing the group one instruction at a time in program order.
- R5: Opcode encoding (3 bits) is: 0 no-op; 1 load the 16-bit immediate; 2 add a+b; 3 subtract a-b; 4 bitwise and; 5 bitwise or; 6 branch-compare, which writes nothing. Arithmetic wraps modulo 2^16.
- R6: A slot's destination completion bit is set one clock edge after both of its source completion bits are set. A load-immediate slot completes one edge after it is filled. No-op and squashed slots count as complete at once. With back-to-back fill, `retire` is first seen one cycle after the fourth fill when the last slot is a no-op or squashed, or when it has already completed; when the last slot must still execute, it is first seen two cycles after.
- R7: `retire` is high only when the partition is full and every slot is complete. At that clock edge the architectural registers take the final bundle values and `full` drops.
- R8: The architectural registers change only at a retirement edge or on reset.
- R9: A branch-compare whose two operands are equal is mispredicted. It raises `mispredict`, which stays high until retirement, and turns every younger slot into a pass-through no-op. Older slots and the branch itself are unaffected.
- R10: A reset applied while the partition is partly filled discards the group: `full` goes low and the architectural registers return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fill_valid | input | 1 | An instruction is offered for fill |
| fill_op | input | 3 | Opcode of the offered instruction |
| fill_dst | input | 2 | Destination register index |
| fill_srca | input | 2 | First source register index |
| fill_srcb | input | 2 | Second source register index |
| fill_imm | input | 16 | Immediate for the load-immediate opcode |
| full | output | 1 | All slots occupied; fill blocked |
| retire | output | 1 | Group completes; registers latch at this edge |
| mispredict | output | 1 | A branch-compare in the group was mispredicted |
| arch_regs | output | 64 | Architectural registers, register r at bits r*16 +: 16 |

## Verification
The hardest case to reach is a squash that must reach slots not yet present: the branch resolves while younger slots are still empty, and those slots are filled on later cycles. Their writes must still vanish, and the partition must still retire on time. The stimulus places a taken branch-compare in the first slot and in the second slot, and then fills load-immediate instructions behind it. It checks that the destination registers keep their old values, that `mispredict` is high at retirement, and that the retire latency falls to one cycle. A further vector offers junk instructions during the full period to show that they never enter.

// File: rtl/ipw_pkg.sv
package ipw_pkg;

    parameter int unsigned NSLOT = 4;
    parameter int unsigned NREG  = 4;
    parameter int unsigned XLEN  = 16;

    localparam int unsigned RIDX_W = $clog2(NREG);
    localparam int unsigned CNT_W  = $clog2(NSLOT + 1);

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_SET = 3'd1,
        OP_ADD = 3'd2,
        OP_SUB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_BEQ = 3'd6
    } op_e;

    typedef logic [RIDX_W-1:0]          ridx_t;
    typedef logic [XLEN-1:0]            word_t;
    typedef logic [NREG-1:0][XLEN-1:0]  regvec_t;
    typedef logic [NREG-1:0]            cmask_t;

    typedef struct packed {
        op_e   op;
        ridx_t dst;
        ridx_t sa;
        ridx_t sb;
        word_t imm;
    } uop_t;

    function automatic word_t alu_eval(op_e op, word_t a, word_t b, word_t imm);
        word_t r;
        case (op)
            OP_SET:  r = imm;
            OP_ADD:  r = a + b;
            OP_SUB:  r = a - b;
            OP_AND:  r = a & b;
            OP_OR:   r = a | b;
            default: r = a;
        endcase
        return r;
    endfunction

    function automatic logic writes_dst(op_e op);
        return (op == OP_SET) || (op == OP_ADD) || (op == OP_SUB) ||
               (op == OP_AND) || (op == OP_OR);
    endfunction

    function automatic logic reads_srcs(op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
               (op == OP_OR)  || (op == OP_BEQ);
    endfunction

endpackage

// File: rtl/ipw_fill_ctrl.sv
module ipw_fill_ctrl
    import ipw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_valid,
    input  logic             retire,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic [NSLOT-1:0] load_sel
);

    logic [CNT_W-1:0] count_q;
    logic             accept;

    assign count  = count_q;
    assign full   = (count_q == CNT_W'(NSLOT));
    assign accept = fill_valid && !full;

    for (genvar s = 0; s < NSLOT; s++) begin : g_sel
        assign load_sel[s] = accept && (count_q == CNT_W'(s));
    end

    always_ff @(posedge clk) begin
        if (rst || retire) begin
            count_q <= '0;
        end else if (accept) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ipw_slot.sv
module ipw_slot
    import ipw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    clear,
    input  logic    load,
    input  uop_t    load_uop,
    input  regvec_t in_data,
    input  cmask_t  in_done,
    input  logic    squash_in,
    output regvec_t out_data,
    output cmask_t  out_done,
    output logic    squash_out,
    output logic    complete
);

    logic  valid_q;
    logic  exec_q;
    uop_t  uop_q;
    word_t opa;
    word_t opb;
    logic  src_ready;
    logic  passthru;
    logic  branch_hit;

    assign opa       = in_data[uop_q.sa];
    assign opb       = in_data[uop_q.sb];
    assign src_ready = reads_srcs(uop_q.op) ? (in_done[uop_q.sa] && in_done[uop_q.sb]) : 1'b1;
    assign passthru  = !valid_q || squash_in || !writes_dst(uop_q.op);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            valid_q <= 1'b0;
            exec_q  <= 1'b0;
            uop_q   <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            exec_q  <= 1'b0;
            uop_q   <= load_uop;
        end else if (valid_q && src_ready) begin
            exec_q  <= 1'b1;
        end
    end

    always_comb begin
        out_data = in_data;
        out_done = in_done;
        if (!passthru) begin
            out_data[uop_q.dst] = alu_eval(uop_q.op, opa, opb, uop_q.imm);
            out_done[uop_q.dst] = exec_q;
        end
    end

    assign branch_hit = valid_q && !squash_in && (uop_q.op == OP_BEQ) && src_ready && (opa == opb);
    assign squash_out = squash_in || branch_hit;
    assign complete   = valid_q && (squash_in || (uop_q.op == OP_NOP) || exec_q);

endmodule

// File: rtl/ipw_arch_file.sv
module ipw_arch_file
    import ipw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    commit,
    input  regvec_t next_state,
    output regvec_t state
);

    regvec_t state_q;

    assign state = state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (commit) begin
            state_q <= next_state;
        end
    end

endmodule

// File: rtl/ipw_window.sv
module ipw_window
    import ipw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fill_valid,
    input  logic [2:0]           fill_op,
    input  logic [1:0]           fill_dst,
    input  logic [1:0]           fill_srca,
    input  logic [1:0]           fill_srcb,
    input  logic [15:0]          fill_imm,
    output logic                 full,
    output logic                 retire,
    output logic                 mispredict,
    output logic [63:0]          arch_regs
);

    logic [CNT_W-1:0] fill_count;
    logic [NSLOT-1:0] load_sel;
    logic [NSLOT-1:0] slot_complete;
    uop_t             fill_uop;
    regvec_t          arch_q;
    regvec_t          link_data [NSLOT+1];
    cmask_t           link_done [NSLOT+1];
    logic             squash_link [NSLOT+1];

    assign fill_uop = '{op: op_e'(fill_op), dst: ridx_t'(fill_dst), sa: ridx_t'(fill_srca),
                        sb: ridx_t'(fill_srcb), imm: word_t'(fill_imm)};

    ipw_fill_ctrl u_fill (
        .clk        (clk),
        .rst        (rst),
        .fill_valid (fill_valid),
        .retire     (retire),
        .count      (fill_count),
        .full       (full),
        .load_sel   (load_sel)
    );

    assign link_data[0]   = arch_q;
    assign link_done[0]   = '1;
    assign squash_link[0] = 1'b0;

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        ipw_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .clear      (retire),
            .load       (load_sel[s]),
            .load_uop   (fill_uop),
            .in_data    (link_data[s]),
            .in_done    (link_done[s]),
            .squash_in  (squash_link[s]),
            .out_data   (link_data[s+1]),
            .out_done   (link_done[s+1]),
            .squash_out (squash_link[s+1]),
            .complete   (slot_complete[s])
        );
    end

    assign retire     = full && (&slot_complete) && (&link_done[NSLOT]);
    assign mispredict = squash_link[NSLOT];

    ipw_arch_file u_arch (
        .clk        (clk),
        .rst        (rst),
        .commit     (retire),
        .next_state (link_data[NSLOT]),
        .state      (arch_q)
    );

    assign arch_regs = arch_q;

endmodule

// File: rtl/ipw_checker.sv
module ipw_checker
    import ipw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             fill_valid,
    input logic             full,
    input logic             retire,
    input logic             mispredict,
    input logic [CNT_W-1:0] fill_count,
    input logic [63:0]      arch_regs
);

    // R2: an accepted fill advances the slot pointer by one
    p_fill_advance_r2: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !full) |=> (fill_count == $past(fill_count) + CNT_W'(1)));

    // R3: a full partition stays full until it retires
    p_full_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (full && !retire) |=> full);

    // R7: retirement only from a full partition
    p_retire_needs_full_r7: assert property (@(posedge clk) disable iff (rst)
        retire |-> full);

    // R7: retirement empties the partition
    p_retire_empties_r7: assert property (@(posedge clk) disable iff (rst)
        retire |=> (fill_count == '0 && !full));

    // R8: architectural state moves only on retirement
    p_arch_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !retire |=> $stable(arch_regs));

    // R9: a mispredict needs an occupied partition
    p_squash_occupied_r9: assert property (@(posedge clk) disable iff (rst)
        mispredict |-> (fill_count != '0));

endmodule

bind ipw_window ipw_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .fill_valid (fill_valid),
    .full       (full),
    .retire     (retire),
    .mispredict (mispredict),
    .fill_count (fill_count),
    .arch_regs  (arch_regs)
);

// File: tb/sim_ipw_window.sv
module sim_ipw_window;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 6;

    function automatic logic [24:0] ins(int op, int d, int a, int b, logic [15:0] imm);
        return {3'(op), 2'(d), 2'(a), 2'(b), imm};
    endfunction

    // opcodes: 0 nop, 1 set, 2 add, 3 sub, 4 and, 5 or, 6 beq
    localparam logic [24:0] PROG [NVEC][4] = '{
        '{ins(1,0,0,0,16'h1234), ins(1,1,0,0,16'h0F0F), ins(2,2,0,1,16'h0), ins(3,3,0,1,16'h0)},
        '{ins(4,0,0,1,16'h0),    ins(5,1,0,1,16'h0),    ins(3,2,1,0,16'h0), ins(2,3,2,2,16'h0)},
        '{ins(1,0,0,0,16'h0005), ins(6,0,1,1,16'h0),    ins(1,2,0,0,16'hFFFF), ins(2,3,0,0,16'h0)},
        '{ins(6,0,0,1,16'h0),    ins(1,2,0,0,16'h8000), ins(2,3,2,2,16'h0), ins(0,0,0,0,16'h0)},
        '{ins(6,0,3,3,16'h0),    ins(1,0,0,0,16'h0001), ins(1,1,0,0,16'h0002), ins(1,2,0,0,16'h0003)},
        '{ins(3,0,3,0,16'h0),    ins(5,1,0,2,16'h0),    ins(4,2,1,1,16'h0), ins(6,0,2,0,16'h0)}
    };
    localparam logic [15:0] EXP_R [NVEC][4] = '{
        '{16'h1234, 16'h0F0F, 16'h2143, 16'h0325},
        '{16'h0204, 16'h0F0F, 16'h0D0B, 16'h1A16},
        '{16'h0005, 16'h0F0F, 16'h0D0B, 16'h1A16},
        '{16'h0005, 16'h0F0F, 16'h8000, 16'h0000},
        '{16'h0005, 16'h0F0F, 16'h8000, 16'h0000},
        '{16'hFFFB, 16'hFFFB, 16'hFFFB, 16'h0000}
    };
    localparam int   EXP_LAT [NVEC] = '{2, 2, 1, 1, 1, 2};
    localparam logic EXP_MIS [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
    localparam logic JUNK    [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

    logic        clk = 1'b0;
    logic        rst;
    logic        fill_valid;
    logic [2:0]  fill_op;
    logic [1:0]  fill_dst;
    logic [1:0]  fill_srca;
    logic [1:0]  fill_srcb;
    logic [15:0] fill_imm;
    logic        full;
    logic        retire;
    logic        mispredict;
    logic [63:0] arch_regs;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipw_window u0 (
        .clk        (clk),
        .rst        (rst),
        .fill_valid (fill_valid),
        .fill_op    (fill_op),
        .fill_dst   (fill_dst),
        .fill_srca  (fill_srca),
        .fill_srcb  (fill_srcb),
        .fill_imm   (fill_imm),
        .full       (full),
        .retire     (retire),
        .mispredict (mispredict),
        .arch_regs  (arch_regs)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(logic v, logic [24:0] w);
        fill_valid = v;
        {fill_op, fill_dst, fill_srca, fill_srcb, fill_imm} = w;
    endtask

    task automatic check_regs(string req, int v);
        for (int r = 0; r < 4; r++)
            chk(req, 32'(arch_regs[r*16 +: 16]), 32'(EXP_R[v][r]));
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b0, '0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1 full", 32'(full), 0);
        chk("R1 retire", 32'(retire), 0);
        chk("R1 mispredict", 32'(mispredict), 0);
        chk("R1 arch", 32'(arch_regs != 64'h0), 0);

        for (int v = 0; v < NVEC; v++) begin
            int lat;
            // R2 fill one per cycle
            for (int k = 0; k < 4; k++) begin
                drive(1'b1, PROG[v][k]);
                @(negedge clk);
            end
            // R3: junk offered while full must be ignored
            if (JUNK[v]) drive(1'b1, ins(1, 0, 0, 0, 16'hDEAD));
            else         drive(1'b0, '0);
            chk("R2 full after four fills", 32'(full), 1);
            lat = 1;
            while (!retire && lat < 12) begin
                @(negedge clk);
                lat++;
            end
            // R6 completion timing, R9 mispredict level at retirement
            chk("R6 retire latency", 32'(lat), 32'(EXP_LAT[v]));
            chk("R9 mispredict", 32'(mispredict), 32'(EXP_MIS[v]));
            @(negedge clk);
            drive(1'b0, '0);
            // R4/R5/R7 retired values, R3/R9 squashed or blocked writes absent
            check_regs("R4 R5 R7 arch", v);
            chk("R7 full after retire", 32'(full), 0);
            // R8 no change without retirement
            @(negedge clk);
            chk("R8 arch stable", 32'(arch_regs[15:0]), 32'(EXP_R[v][0]));
        end

        // R10: reset with a partly filled group
        drive(1'b1, ins(1, 0, 0, 0, 16'h7777));
        @(negedge clk);
        drive(1'b1, ins(1, 1, 0, 0, 16'h6666));
        @(negedge clk);
        drive(1'b0, '0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R10 full", 32'(full), 0);
        chk("R10 arch", 32'(arch_regs != 64'h0), 0);
        chk("R10 mispredict", 32'(mispredict), 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule